// File: doc/BRIEF.md
# Palette Colour Expansion Unit

This unit turns a pixel index into a 24-bit colour, 8 bits per channel, for the palettised display modes. It sits behind the pixel fetch logic of a display controller: each cycle the fetch side presents a mode code, a 5:6:5 / 5:5:5+intensity format select, and an index. The unit then produces the matching colour on a registered output.

In the passive-panel modes the colour is built from 4-bit nibbles held in three lookup registers, one per channel. The red and green registers are 32 bits wide and the blue register is 16 bits wide. In the active-panel modes the index addresses an external palette RAM with a synchronous read port. The 16-bit entry that comes back is unpacked in one of two packings. Modes that are not palettised give black. Every channel is carried internally as 6 bits and widened to 8 bits with two zero LSBs.

The index path holds one register and the colour path holds another. The synchronous palette read therefore falls between the two, and passive and active colours arrive with the same latency.

Top module: `pal_color_expand`

## Requirements
- R1: While `rst_n` is low, and after its release until the first index is loaded, `rgb_out` is 0.
- R2: Inputs present at rising edge k show on `rgb_out` after rising edge k+1, packed {red[23:16], green[15:8], blue[7:0]}. One new index is accepted every cycle. `pram_addr` is driven combinationally in the same cycle as the index. The palette RAM returns `pram_rdata` for that address after edge k.
- R3: Mode codes 0, 1, 2 and 3 are passive with 1, 2, 4 and 8 bits per pixel. Codes 8, 9, 10 and 11 are the active counterparts with the same bit counts. Index bits above the mode's bit count are ignored. In active modes `pram_addr` is the masked index; in every other mode it is 0.
- R4: In passive modes 0 to 2, the masked index i selects nibble i, that is bits 4i+3..4i, of each lookup register. A nibble position beyond a register's width gives 0 for that channel.
- R5: In passive mode 3 the red nibble is selected by index bits 7:5, the green nibble by index bits 4:2 and the blue nibble by index bits 1:0.
- R6: A lookup nibble n becomes the 8-bit channel {n, 4'b0000}.
- R7: In an active mode with `fmt565`=1 the entry e gives red {e[15:11],0}, green e[10:5] and blue {e[4:0],0} as 6-bit channels. Each 6-bit value is output as {value, 2'b00}.
- R8: In an active mode with `fmt565`=0 the entry e gives red {e[15:11],e[0]}, green {e[10:6],e[0]} and blue {e[5:1],e[0]}. Each 6-bit value is output as {value, 2'b00}.
- R9: Mode codes 4 to 7 and 12 to 15 give `rgb_out` = 0 with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Pixel mode code |
| fmt565 | input | 1 | Entry packing: 1 = 5:6:5, 0 = 5:5:5 plus shared intensity bit |
| lut_red | input | 32 | Red lookup nibbles |
| lut_green | input | 32 | Green lookup nibbles |
| lut_blue | input | 16 | Blue lookup nibbles |
| pix_index | input | 8 | Pixel index |
| pram_addr | output | 8 | Palette RAM read address |
| pram_rdata | input | 16 | Palette RAM read data, one cycle after the address |
| rgb_out | output | 24 | Registered colour |

## Verification
The bench uses indices whose upper bits are set in the narrow modes. A design that failed to mask them would read the wrong nibble or palette entry. In 4-bit passive mode it uses nibble positions past the end of the blue and red registers, where a design that wrapped the position would output a colour instead of black. In 8-bit passive mode it drives index fields that differ per channel, so using one field for all three channels shows up as a wrong colour. It also uses all-ones and intensity-only palette entries in both packings, which catch a shared intensity bit that was dropped or used in the wrong packing. Back-to-back mode changes in the random run catch any misalignment between the registered mode and the palette read data.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = 16;
    localparam int CH_W    = 8;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_PASSIVE = 2'd1,
        KIND_ACTIVE  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic              fmt565;
        logic [3*CH_W-1:0] pas_rgb;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        logic [3*CH_W-1:0] rgb;
    } state_t;

    function automatic logic [IDX_W-1:0] mask_index(input logic [1:0] depth,
                                                     input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] m;
        case (depth)
            2'd0:    m = IDX_W'(8'h01);
            2'd1:    m = IDX_W'(8'h03);
            2'd2:    m = IDX_W'(8'h0f);
            default: m = IDX_W'(8'hff);
        endcase
        return idx & m;
    endfunction
endpackage

// File: rtl/pal_nibble_pick.sv
module pal_nibble_pick #(
    parameter int REG_W = 32,
    parameter int SEL_W = 4
) (
    input  logic [REG_W-1:0] lut,
    input  logic [SEL_W-1:0] sel,
    output logic [3:0]       nib
);
    localparam int NIB_N = REG_W / 4;

    logic [3:0] slot [NIB_N];

    for (genvar n = 0; n < NIB_N; n++) begin : g_slot
        assign slot[n] = lut[4*n +: 4];
    end

    always_comb begin
        nib = 4'h0;
        for (int n = 0; n < NIB_N; n++) begin
            if (int'(sel) == n) nib = slot[n];
        end
    end
endmodule

// File: rtl/pal_entry_unpack.sv
module pal_entry_unpack (
    input  logic [15:0] entry,
    input  logic        fmt565,
    output logic [5:0]  red6,
    output logic [5:0]  grn6,
    output logic [5:0]  blu6
);
    always_comb begin
        if (fmt565) begin
            red6 = {entry[15:11], 1'b0};
            grn6 = entry[10:5];
            blu6 = {entry[4:0], 1'b0};
        end else begin
            red6 = {entry[15:11], entry[0]};
            grn6 = {entry[10:6], entry[0]};
            blu6 = {entry[5:1], entry[0]};
        end
    end
endmodule

// File: rtl/pal_color_expand.sv
module pal_color_expand
    import pal_pkg::*;
#(
    parameter int RED_W = 32,
    parameter int GRN_W = 32,
    parameter int BLU_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          mode,
    input  logic                fmt565,
    input  logic [RED_W-1:0]    lut_red,
    input  logic [GRN_W-1:0]    lut_green,
    input  logic [BLU_W-1:0]    lut_blue,
    input  logic [IDX_W-1:0]    pix_index,
    output logic [IDX_W-1:0]    pram_addr,
    input  logic [ENTRY_W-1:0]  pram_rdata,
    output logic [3*CH_W-1:0]   rgb_out
);
    localparam int SEL_W = 4;

    state_t st_d, st_q;

    kind_e            kind_in;
    logic [IDX_W-1:0] idx_m;
    logic [SEL_W-1:0] sel_r, sel_g, sel_b;
    logic [3:0]       nib_r, nib_g, nib_b;
    logic [5:0]       red6, grn6, blu6;

    always_comb begin
        case (mode[3:2])
            2'b00:   kind_in = KIND_PASSIVE;
            2'b10:   kind_in = KIND_ACTIVE;
            default: kind_in = KIND_NONE;
        endcase
        idx_m = mask_index(mode[1:0], pix_index);
        if (mode[1:0] == 2'd3) begin
            sel_r = {1'b0, idx_m[7:5]};
            sel_g = {1'b0, idx_m[4:2]};
            sel_b = {2'b00, idx_m[1:0]};
        end else begin
            sel_r = idx_m[3:0];
            sel_g = idx_m[3:0];
            sel_b = idx_m[3:0];
        end
    end

    assign pram_addr = (kind_in == KIND_ACTIVE) ? idx_m : '0;

    pal_nibble_pick #(.REG_W(RED_W), .SEL_W(SEL_W)) i_pick_r (
        .lut(lut_red), .sel(sel_r), .nib(nib_r));
    pal_nibble_pick #(.REG_W(GRN_W), .SEL_W(SEL_W)) i_pick_g (
        .lut(lut_green), .sel(sel_g), .nib(nib_g));
    pal_nibble_pick #(.REG_W(BLU_W), .SEL_W(SEL_W)) i_pick_b (
        .lut(lut_blue), .sel(sel_b), .nib(nib_b));

    pal_entry_unpack i_unpack (
        .entry (pram_rdata),
        .fmt565(st_q.s1.fmt565),
        .red6  (red6),
        .grn6  (grn6),
        .blu6  (blu6)
    );

    always_comb begin
        st_d = st_q;
        st_d.s1.kind    = kind_in;
        st_d.s1.fmt565  = fmt565;
        st_d.s1.pas_rgb = {nib_r, 4'h0, nib_g, 4'h0, nib_b, 4'h0};
        case (st_q.s1.kind)
            KIND_PASSIVE: st_d.rgb = st_q.s1.pas_rgb;
            KIND_ACTIVE:  st_d.rgb = {red6, 2'b00, grn6, 2'b00, blu6, 2'b00};
            default:      st_d.rgb = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rgb_out = st_q.rgb;

    // R9: non-palettised index gives black on the next edge
    a_r9_nonpal_black: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.kind == KIND_NONE) |=> (rgb_out == '0));

    // R6: passive colours carry zero low nibbles in every channel
    a_r6_nibble_widen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.kind == KIND_PASSIVE) |=>
        (rgb_out[3:0] == 4'h0 && rgb_out[11:8] == 4'h0 && rgb_out[19:16] == 4'h0));

    // R7: 5:6:5 red and blue are left-justified, low bit zero
    a_r7_565_justify: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.kind == KIND_ACTIVE && st_q.s1.fmt565) |=>
        (rgb_out[2] == 1'b0 && rgb_out[18] == 1'b0 && rgb_out[23:19] == $past(pram_rdata[15:11])));

    // R8: intensity bit is the channel LSB of all three channels
    a_r8_shared_intensity: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1.kind == KIND_ACTIVE && !st_q.s1.fmt565) |=>
        (rgb_out[2] == $past(pram_rdata[0]) && rgb_out[10] == $past(pram_rdata[0])
         && rgb_out[18] == $past(pram_rdata[0])));

    // R3: the palette address never exceeds the mode's index range
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd8) |-> (pram_addr[IDX_W-1:1] == '0));
endmodule

// File: tb/test_pal_color_expand.sv
module test_pal_color_expand;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd4;
    logic        fmt565 = 1'b0;
    logic [31:0] lut_red = '0;
    logic [31:0] lut_green = '0;
    logic [15:0] lut_blue = '0;
    logic [7:0]  pix_index = '0;
    logic [7:0]  pram_addr;
    logic [15:0] pram_rdata = '0;
    logic [23:0] rgb_out;

    logic [15:0] mem [256];

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [23:0] exp0, exp1;
    string       tag0, tag1;
    bit          v0 = 0, v1 = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) pram_rdata <= mem[pram_addr];

    pal_color_expand i_pal_color_expand (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fmt565(fmt565),
        .lut_red(lut_red), .lut_green(lut_green), .lut_blue(lut_blue),
        .pix_index(pix_index), .pram_addr(pram_addr),
        .pram_rdata(pram_rdata), .rgb_out(rgb_out));

    function automatic int masked(input logic [3:0] m, input logic [7:0] ix);
        int bpp;
        bpp = 1 << m[1:0];
        return int'(ix) & ((1 << bpp) - 1);
    endfunction

    function automatic logic [7:0] exp_addr(input logic [3:0] m, input logic [7:0] ix);
        if (m[3:2] == 2'b10) return 8'(masked(m, ix));
        return 8'h00;
    endfunction

    function automatic logic [3:0] nib_of(input logic [31:0] r, input int w, input int pos);
        if (4 * pos + 4 > w) return 4'h0;
        return 4'((r >> (4 * pos)) & 32'hf);
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [3:0] m, input logic f,
            input logic [31:0] r, input logic [31:0] g, input logic [15:0] b,
            input logic [7:0] ix, input logic [15:0] e);
        int mi;
        logic [3:0] nr, ng, nb;
        logic [5:0] r6, g6, b6;
        mi = masked(m, ix);
        if (m[3:2] == 2'b00) begin
            if (m[1:0] == 2'd3) begin
                nr = nib_of(r, 32, (mi >> 5) & 7);
                ng = nib_of(g, 32, (mi >> 2) & 7);
                nb = nib_of({16'h0, b}, 16, mi & 3);
            end else begin
                nr = nib_of(r, 32, mi);
                ng = nib_of(g, 32, mi);
                nb = nib_of({16'h0, b}, 16, mi);
            end
            return {nr, 4'h0, ng, 4'h0, nb, 4'h0};
        end
        if (m[3:2] == 2'b10) begin
            r6 = {e[15:11], f ? 1'b0 : e[0]};
            g6 = f ? e[10:5] : {e[10:6], e[0]};
            b6 = f ? {e[4:0], 1'b0} : {e[5:1], e[0]};
            return {r6, 2'b00, g6, 2'b00, b6, 2'b00};
        end
        return 24'h0;
    endfunction

    task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic [3:0] m, input logic f,
            input logic [31:0] r, input logic [31:0] g, input logic [15:0] b,
            input logic [7:0] ix);
        @(negedge clk);
        if (v1) check(tag1, rgb_out, exp1);
        exp1 = exp0; tag1 = tag0; v1 = v0;
        exp0 = exp_rgb(m, f, r, g, b, ix, mem[masked(m, ix)]);
        tag0 = tag; v0 = 1;
        mode = m; fmt565 = f; lut_red = r; lut_green = g; lut_blue = b; pix_index = ix;
        #1;
        check({"R3 addr ", tag}, {16'h0, pram_addr}, {16'h0, exp_addr(m, ix)});
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] m;
        logic [31:0] seedv;
        seedv = $urandom(32'h5eed);
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        mem[3] = 16'hFFFF;
        mem[4] = 16'h0001;
        mem[1] = 16'h8421;
        repeat (4) @(negedge clk);
        check("R1 in reset", rgb_out, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rgb_out, 24'h0);

        // directed corner cases
        step("R2 R6 R4 mode2 idx5", 4'd2, 0, 32'h00A00000, 32'h00B00000, 16'h1234, 8'h05);
        step("R4 mode2 idx9 beyond regs", 4'd2, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 8'h09);
        step("R4 mode2 idx3 blue last", 4'd2, 0, 32'h00001000, 32'h00002000, 16'h7000, 8'h03);
        step("R3 mode0 upper bits", 4'd0, 0, 32'h000000F1, 32'h000000E2, 16'h00D3, 8'hFE);
        step("R3 mode1 upper bits", 4'd1, 0, 32'h0000ABCD, 32'h00001234, 16'h5678, 8'hFD);
        step("R5 mode3 split fields", 4'd3, 0, 32'h87654321, 32'hFEDCBA98, 16'hC0DE, 8'b011_101_10);
        step("R5 mode3 top fields", 4'd3, 0, 32'h9ABCDEF0, 32'h13579BDF, 16'h2468, 8'hFF);
        step("R7 565 all ones", 4'd11, 1, '0, '0, '0, 8'h03);
        step("R8 5551 all ones", 4'd11, 0, '0, '0, '0, 8'h03);
        step("R8 intensity only", 4'd10, 0, '0, '0, '0, 8'h04);
        step("R7 565 intensity ignored", 4'd10, 1, '0, '0, '0, 8'h04);
        step("R3 R8 mode8 upper bits", 4'd8, 0, '0, '0, '0, 8'hF1);
        step("R9 mode4", 4'd4, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 8'h03);
        step("R9 mode12", 4'd12, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 8'h03);
        step("R2 back to passive", 4'd0, 0, 32'h00000070, 32'h00000080, 16'h0090, 8'h01);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            m = 4'($urandom_range(0, 15));
            if (m[3:2] == 2'b00)
                step(m[1:0] == 2'd3 ? "R5 rand" : "R4 rand", m, 1'($urandom),
                     $urandom, $urandom, 16'($urandom), 8'($urandom));
            else if (m[3:2] == 2'b10) begin
                logic f;
                f = 1'($urandom);
                step(f ? "R7 rand" : "R8 rand", m, f,
                     $urandom, $urandom, 16'($urandom), 8'($urandom));
            end else
                step("R9 rand", m, 1'($urandom), $urandom, $urandom, 16'($urandom), 8'($urandom));
        end
        step("R9 flush", 4'd5, 0, '0, '0, '0, 8'h00);
        step("R9 flush", 4'd5, 0, '0, '0, '0, 8'h00);
        step("R9 flush", 4'd5, 0, '0, '0, '0, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule